// File: doc/BRIEF.md
# Two-Player Die Display

This block is a pocket die for two players. A 32-bit pseudo-random shift register runs on every enabled clock, whether or not anyone is playing. Each player has one button input. While a player's button is high, the block draws a fresh value from the generator in every enabled cycle. It reduces that value to a face from 1 to 6 and shows it as a seven-segment pattern on the digit that belongs to that player.

Player one owns the rightmost digit and player two owns the leftmost digit. The digit enables are active low. When no button is pressed, the display keeps showing the last roll. Button debouncing is left to the surrounding logic, and so is scanning across several digits. A clock-enable input freezes all state, so a slow tick can pace the block or a model can follow it cycle by cycle.

Top module: `duo_die_display`

## Requirements
- R1: A synchronous active-high reset sets the segment output to the code for 0 (8'hC0) and the digit enable to 4'b1111, so all digits are dark. It also clears the seeded flag of the generator.
- R2: In an enabled cycle with the player-one input high, the next clock edge latches the rolled face's segment code and sets the digit enable to 4'b1110.
- R3: In an enabled cycle with the player-one input low and the player-two input high, the next edge latches the rolled face's code and sets the digit enable to 4'b0111.
- R4: When both player inputs are high in the same enabled cycle, player one wins and the enable becomes 4'b1110.
- R5: In an enabled cycle with neither input high, the segment output and the digit enable keep their values.
- R6: The generator is a 32-bit right-shifting register. The new bit 31 is the XOR of bits 0, 10, 30 and 31. In the first enabled cycle after reset, the generator starts from the seed 11. In every enabled cycle it is stepped twice, and the result of the second step is stored. The face rolled in a cycle is that second-step word modulo 6, plus 1. So a roll in the first enabled cycle after reset gives face 1.
- R7: The generator keeps stepping in enabled cycles without a press. The face therefore depends on how many enabled cycles have passed since reset.
- R8: When the clock enable is low, no state changes. The outputs hold, and the generator does not advance.
- R9: Segment codes are active low, with bit 0 for segment a through bit 6 for segment g, and bit 7 for the decimal point, which is always high. Faces 1 to 6 map to F9, A4, B0, 99, 92 and 82 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; gates every state update |
| p1_press | input | 1 | Player one button, high while pressed |
| p2_press | input | 1 | Player two button, high while pressed |
| seg_o | output | 8 | Active-low segment pattern, bit 7 decimal point |
| dig_en_n_o | output | 4 | Active-low digit enables |

## Verification
Two functions can fall in the same cycle. A press by both players collides in the output register, and a press of either player coincides with the background stepping of the generator. The bench holds both buttons high together and checks that the enable reads 4'b1110 and that the segment code is the one a bench-side generator model predicts. That model steps twice per enabled cycle, so a wrong stepping count or a wrong winner changes the face it expects. Presses made while the clock enable is low must leave the display unchanged. The next enabled roll must still match the model, which proves the generator stood still.

// File: rtl/dice_pkg.sv
package dice_pkg;

  localparam int SEG_W  = 8;
  localparam int FACE_W = 3;

  // Active-low common-anode codes, bit0 = a ... bit6 = g, bit7 = dp (kept off)
  function automatic logic [SEG_W-1:0] seg_encode(input logic [FACE_W-1:0] v);
    logic [SEG_W-1:0] code;
    case (v)
      3'd0:    code = 8'hC0;
      3'd1:    code = 8'hF9;
      3'd2:    code = 8'hA4;
      3'd3:    code = 8'hB0;
      3'd4:    code = 8'h99;
      3'd5:    code = 8'h92;
      3'd6:    code = 8'h82;
      default: code = 8'hFF;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/lfsr_stepper.sv
module lfsr_stepper #(
  parameter int          W        = 32,
  parameter logic [W-1:0] SEED     = 32'd11,
  parameter logic [W-1:0] TAP_MASK = 32'hC000_0401,
  parameter int          STEPS    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  output logic [W-1:0] roll_word_o
);

  logic [W-1:0] state_q;
  logic         seeded_q;
  logic [W-1:0] chain [0:STEPS];

  assign chain[0] = seeded_q ? state_q : SEED;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign chain[i+1] = {^(chain[i] & TAP_MASK), chain[i][W-1:1]};
  end

  assign roll_word_o = chain[STEPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      seeded_q <= 1'b0;
    end else if (ce) begin
      state_q  <= chain[STEPS];
      seeded_q <= 1'b1;
    end
  end

endmodule

// File: rtl/face_mapper.sv
module face_mapper
  import dice_pkg::*;
#(
  parameter int W     = 32,
  parameter int FACES = 6
) (
  input  logic [W-1:0]     word_i,
  output logic [SEG_W-1:0] seg_code_o
);

  logic [W-1:0]      rem;
  logic [FACE_W-1:0] face;

  assign rem        = word_i % W'(FACES);
  assign face       = rem[FACE_W-1:0] + FACE_W'(1);
  assign seg_code_o = seg_encode(face);

endmodule

// File: rtl/duo_die_display.sv
module duo_die_display
  import dice_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [W-1:0] SEED     = 32'd11,
  parameter logic [W-1:0] TAP_MASK = 32'hC000_0401,
  parameter int          STEPS    = 2,
  parameter int          FACES    = 6,
  parameter int          DIGITS   = 4,
  parameter logic [DIGITS-1:0] P1_EN_N   = 4'b1110,
  parameter logic [DIGITS-1:0] P2_EN_N   = 4'b0111,
  parameter logic [DIGITS-1:0] IDLE_EN_N = 4'b1111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              p1_press,
  input  logic              p2_press,
  output logic [SEG_W-1:0]  seg_o,
  output logic [DIGITS-1:0] dig_en_n_o
);

  logic [W-1:0]     roll_word;
  logic [SEG_W-1:0] roll_code;

  lfsr_stepper #(
    .W(W), .SEED(SEED), .TAP_MASK(TAP_MASK), .STEPS(STEPS)
  ) u_gen (
    .clk         (clk),
    .rst         (rst),
    .ce          (ce),
    .roll_word_o (roll_word)
  );

  face_mapper #(
    .W(W), .FACES(FACES)
  ) u_map (
    .word_i     (roll_word),
    .seg_code_o (roll_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o      <= seg_encode('0);
      dig_en_n_o <= IDLE_EN_N;
    end else if (ce) begin
      if (p1_press) begin
        seg_o      <= roll_code;
        dig_en_n_o <= P1_EN_N;
      end else if (p2_press) begin
        seg_o      <= roll_code;
        dig_en_n_o <= P2_EN_N;
      end
    end
  end

endmodule

// File: rtl/duo_die_display_chk.sv
module duo_die_display_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       p1_press,
  input logic       p2_press,
  input logic [7:0] seg_o,
  input logic [3:0] dig_en_n_o
);

  AST_P1_WINS: assert property (@(posedge clk) disable iff (rst)
    (ce && p1_press) |=> (dig_en_n_o == 4'b1110));          // R2 R4

  AST_P2_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ce && !p1_press && p2_press) |=> (dig_en_n_o == 4'b0111)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ce && !p1_press && !p2_press) |=> ($stable(seg_o) && $stable(dig_en_n_o))); // R5

  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> ($stable(seg_o) && $stable(dig_en_n_o)));     // R8

  AST_DP_OFF: assert property (@(posedge clk) disable iff (rst)
    seg_o[7] == 1'b1);                                       // R9

  AST_EN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (dig_en_n_o == 4'b1111) || (dig_en_n_o == 4'b1110) || (dig_en_n_o == 4'b0111)); // R1 R2 R3

endmodule

bind duo_die_display duo_die_display_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce         (ce),
  .p1_press   (p1_press),
  .p2_press   (p2_press),
  .seg_o      (seg_o),
  .dig_en_n_o (dig_en_n_o)
);

// File: tb/test_duo_die_display.sv
module test_duo_die_display;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce  = 1'b0;
  logic       p1_press = 1'b0;
  logic       p2_press = 1'b0;
  logic [7:0] seg_o;
  logic [3:0] dig_en_n_o;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  duo_die_display i_duo_die_display (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .p1_press   (p1_press),
    .p2_press   (p2_press),
    .seg_o      (seg_o),
    .dig_en_n_o (dig_en_n_o)
  );

  // ---- reference model built from the requirements ----
  function automatic logic [31:0] m_step(input logic [31:0] x);
    return {x[0] ^ x[10] ^ x[30] ^ x[31], x[31:1]};
  endfunction

  function automatic logic [7:0] m_code(input int face);
    case (face)
      1: return 8'hF9;
      2: return 8'hA4;
      3: return 8'hB0;
      4: return 8'h99;
      5: return 8'h92;
      6: return 8'h82;
      default: return 8'hC0;
    endcase
  endfunction

  logic [31:0] m_lfsr;
  logic        m_seeded;
  logic [7:0]  m_seg;
  logic [3:0]  m_en;

  always @(posedge clk) begin : model
    logic [31:0] w;
    if (rst) begin
      m_seeded <= 1'b0;
      m_lfsr   <= '0;
      m_seg    <= 8'hC0;
      m_en     <= 4'b1111;
    end else if (ce) begin
      w = m_seeded ? m_lfsr : 32'd11;
      w = m_step(m_step(w));
      m_lfsr   <= w;
      m_seeded <= 1'b1;
      if (p1_press) begin
        m_seg <= m_code(int'(w % 32'd6) + 1);
        m_en  <= 4'b1110;
      end else if (p2_press) begin
        m_seg <= m_code(int'(w % 32'd6) + 1);
        m_en  <= 4'b0111;
      end
    end
  end

  // ---- check helper ----
  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual seg=%h en=%b expected seg=%h en=%b",
               req, act[11:4], act[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic cycle(input logic a, input logic b, input logic e);
    p1_press = a;
    p2_press = b;
    ce       = e;
    @(negedge clk);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b1; p1_press = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", {seg_o, dig_en_n_o}, {8'hC0, 4'b1111});
    rst = 1'b0; p1_press = 1'b0;
  endtask

  task automatic t_first_roll();
    // seed 11 stepped twice -> 0x40000002, mod 6 = 0 -> face 1
    cycle(1'b1, 1'b0, 1'b1);
    check("R6 first roll after reset", {seg_o, dig_en_n_o}, {8'hF9, 4'b1110});
    check("R2 player one vs model", {seg_o, dig_en_n_o}, {m_seg, m_en});
  endtask

  task automatic t_player_two();
    cycle(1'b0, 1'b0, 1'b1);
    cycle(1'b0, 1'b1, 1'b1);
    check("R3 player two enable", {seg_o, dig_en_n_o}, {m_seg, 4'b0111});
    check("R9 dp bit off", {7'd0, seg_o[7], 4'd0}, {7'd0, 1'b1, 4'd0});
  endtask

  task automatic t_both();
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 1'b1, 1'b1);
      check("R4 both pressed, player one wins", {seg_o, dig_en_n_o}, {m_seg, 4'b1110});
    end
  endtask

  task automatic t_idle_hold();
    logic [11:0] snap;
    cycle(1'b0, 1'b1, 1'b1);
    snap = {seg_o, dig_en_n_o};
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 1'b0, 1'b1);
      check("R5 idle hold", {seg_o, dig_en_n_o}, snap);
    end
    cycle(1'b1, 1'b0, 1'b1);
    check("R7 generator ran while idle", {seg_o, dig_en_n_o}, {m_seg, m_en});
  endtask

  task automatic t_ce_freeze();
    logic [11:0] snap;
    snap = {seg_o, dig_en_n_o};
    for (int i = 0; i < 4; i++) begin
      cycle(i[0], ~i[0], 1'b0);
      check("R8 disabled cycle holds outputs", {seg_o, dig_en_n_o}, snap);
    end
    cycle(1'b0, 1'b1, 1'b1);
    check("R8 generator frozen while disabled", {seg_o, dig_en_n_o}, {m_seg, m_en});
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 60; i++) begin
      cycle((i % 3) == 0, (i % 5) == 1, 1'b1);
      check("R6 R7 roll sequence vs model", {seg_o, dig_en_n_o}, {m_seg, m_en});
      checks++;
      if (!(seg_o inside {8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99, 8'h92, 8'h82})) begin
        failures++;
        $display("FAIL R9 illegal segment code: actual %h expected a face code", seg_o);
      end
    end
  endtask

  initial begin
    t_reset();
    t_first_roll();
    t_player_two();
    t_both();
    t_idle_hold();
    t_ce_freeze();
    t_sweep();
    t_reset();
    t_first_roll();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule